// File: doc/BRIEF.md
# QPSK Four-Phase Soft Symbol Rotator

This block sits between a QPSK soft demapper and a soft-decision decoder. Each incoming pair of signed soft symbols is rotated by one of four phase hypotheses (0, 90, 180 or 270 degrees) before it reaches the decoder. The block uses only swaps and sign changes of the two symbols, so it needs no multipliers.

A 2-bit phase register selects the hypothesis. An external error monitor decides that the decoder has lost lock and sends a single-cycle slip pulse. Each pulse steps the phase register to the next hypothesis. Repeated pulses walk through all four alignments until the decoder locks again. The current phase is visible on a status output. The rotated pair leaves through an output register, and the valid strobe is delayed to match.

Top module: `qpsk_phase_rotator`

## Requirements
- R1: While reset is high and on the first edge after it, `phase_sel` is 0, `out_valid` is 0, and both output symbols are 0.
- R2: With `phase_sel` = 0, a valid pair (a, b) is output as (a, b).
- R3: With `phase_sel` = 1, a valid pair (a, b) is output as (b, -a).
- R4: With `phase_sel` = 2, a valid pair (a, b) is output as (-a, -b).
- R5: With `phase_sel` = 3, a valid pair (a, b) is output as (-b, a).
- R6: Each clock with `slip` high adds one to `phase_sel`, and the value wraps from 3 to 0. Without `slip` the value is held.
- R7: Negating the most negative two's-complement value gives the most positive value. For example, with 4-bit symbols, -8 becomes +7.
- R8: The output pair appears one clock after the input pair. `out_valid` is `in_valid` delayed by one clock.
- R9: A pair that arrives in the same clock as `slip` uses the old phase. The pair in the following clock uses the new phase.
- R10: While `in_valid` is low, the output symbols keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slip | input | 1 | Loss-of-sync pulse; steps the phase hypothesis |
| in_valid | input | 1 | Input pair strobe |
| in_sym_a | input | SYM_W | First soft symbol, signed |
| in_sym_b | input | SYM_W | Second soft symbol, signed |
| out_sym_a | output | SYM_W | Rotated first symbol, signed |
| out_sym_b | output | SYM_W | Rotated second symbol, signed |
| out_valid | output | 1 | Output pair strobe |
| phase_sel | output | 2 | Current phase hypothesis, 0 to 3 |

## Verification
The assertions assume that `slip` and `in_valid` are single-bit synchronous inputs that never go unknown after reset. They also assume that the symbols may take any two's-complement value, including the most negative one. The stimulus holds every input steady between falling edges and draws symbols over the full signed range. It also forces the most negative value in every phase, so the saturation path is always exercised. Slip pulses are sometimes raised together with a valid pair and sometimes on idle clocks. This covers both the old-phase-on-the-same-clock case and the wrap from 3 back to 0.

// File: rtl/rot_pkg.sv
package rot_pkg;

  typedef enum logic [1:0] {
    PH_0   = 2'd0,
    PH_90  = 2'd1,
    PH_180 = 2'd2,
    PH_270 = 2'd3
  } phase_e;

  localparam int LANES = 2;

  function automatic phase_e phase_next(input phase_e cur);
    return phase_e'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/rot_phase_ctrl.sv
module rot_phase_ctrl
  import rot_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   slip,
  output phase_e phase
);

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= PH_0;
    else if (slip) phase_q <= phase_next(phase_q);
  end

  assign phase = phase_q;

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    slip |=> (phase_q == phase_e'($past(phase_q) + 2'd1))); // R6
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !slip |=> $stable(phase_q)); // R6

endmodule

// File: rtl/rot_sat_neg.sv
module rot_sat_neg #(
  parameter int W = 4
) (
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);

  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (din == MOST_NEG) dout = MOST_POS;
    else                 dout = -din;
  end

endmodule

// File: rtl/rot_pair_mux.sv
module rot_pair_mux
  import rot_pkg::*;
#(
  parameter int SYM_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  phase_e                  phase,
  input  logic                    in_valid,
  input  logic signed [SYM_W-1:0] in_a,
  input  logic signed [SYM_W-1:0] in_b,
  output logic signed [SYM_W-1:0] out_a,
  output logic signed [SYM_W-1:0] out_b,
  output logic                    out_valid
);

  localparam logic signed [SYM_W-1:0] MOST_NEG = {1'b1, {(SYM_W-1){1'b0}}};
  localparam logic signed [SYM_W-1:0] MOST_POS = {1'b0, {(SYM_W-1){1'b1}}};

  logic signed [SYM_W-1:0] src [LANES];
  logic signed [SYM_W-1:0] neg [LANES];
  logic signed [SYM_W-1:0] sel_a, sel_b;
  logic signed [SYM_W-1:0] a_q, b_q;
  logic                    v_q;

  assign src[0] = in_a;
  assign src[1] = in_b;

  for (genvar g = 0; g < LANES; g++) begin : g_neg
    rot_sat_neg #(.W(SYM_W)) u_neg (
      .din  (src[g]),
      .dout (neg[g])
    );
  end

  always_comb begin
    unique case (phase)
      PH_0:    begin sel_a = src[0]; sel_b = src[1]; end
      PH_90:   begin sel_a = src[1]; sel_b = neg[0]; end
      PH_180:  begin sel_a = neg[0]; sel_b = neg[1]; end
      default: begin sel_a = neg[1]; sel_b = src[0]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        a_q <= sel_a;
        b_q <= sel_b;
      end
    end
  end

  assign out_a     = a_q;
  assign out_b     = b_q;
  assign out_valid = v_q;

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (v_q == $past(in_valid))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(a_q) && $stable(b_q))); // R10
  AST_PASS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase == PH_0) |=> (a_q == $past(in_a) && b_q == $past(in_b))); // R2
  AST_SWAP_90: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase == PH_90) |=> (a_q == $past(in_b))); // R3
  AST_SWAP_270: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase == PH_270) |=> (b_q == $past(in_a))); // R5
  AST_SAT_NEG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase == PH_180 && in_a == MOST_NEG) |=> (a_q == MOST_POS)); // R7

endmodule

// File: rtl/qpsk_phase_rotator.sv
module qpsk_phase_rotator
  import rot_pkg::*;
#(
  parameter int SYM_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    slip,
  input  logic                    in_valid,
  input  logic signed [SYM_W-1:0] in_sym_a,
  input  logic signed [SYM_W-1:0] in_sym_b,
  output logic signed [SYM_W-1:0] out_sym_a,
  output logic signed [SYM_W-1:0] out_sym_b,
  output logic                    out_valid,
  output logic [1:0]              phase_sel
);

  phase_e phase;

  rot_phase_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .slip  (slip),
    .phase (phase)
  );

  rot_pair_mux #(.SYM_W(SYM_W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .in_valid  (in_valid),
    .in_a      (in_sym_a),
    .in_b      (in_sym_b),
    .out_a     (out_sym_a),
    .out_b     (out_sym_b),
    .out_valid (out_valid)
  );

  assign phase_sel = phase;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (phase_sel == 2'd0 && !out_valid)); // R1

endmodule

// File: tb/qpsk_phase_rotator_tb.sv
module qpsk_phase_rotator_tb;

  localparam int W = 4;
  localparam int MINV = -(1 << (W-1));
  localparam int MAXV = (1 << (W-1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slip = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_sym_a = '0;
  logic signed [W-1:0] in_sym_b = '0;
  logic signed [W-1:0] out_sym_a, out_sym_b;
  logic out_valid;
  logic [1:0] phase_sel;

  int n_checks = 0;
  int n_fail = 0;
  int m_phase = 0;
  int exp_a = 0;
  int exp_b = 0;

  always #10 clk = ~clk;

  qpsk_phase_rotator #(.SYM_W(W)) u_dut (
    .clk(clk), .rst(rst), .slip(slip), .in_valid(in_valid),
    .in_sym_a(in_sym_a), .in_sym_b(in_sym_b),
    .out_sym_a(out_sym_a), .out_sym_b(out_sym_b),
    .out_valid(out_valid), .phase_sel(phase_sel)
  );

  function automatic int sneg(input int x);
    return (x == MINV) ? MAXV : -x;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input logic s, input logic v, input int a, input int b);
    string tag;
    int ea, eb;
    slip = s; in_valid = v;
    in_sym_a = a[W-1:0]; in_sym_b = b[W-1:0];
    case (m_phase)
      0: begin ea = a;       eb = b;       tag = "R2"; end
      1: begin ea = b;       eb = sneg(a); tag = "R3"; end
      2: begin ea = sneg(a); eb = sneg(b); tag = "R4"; end
      default: begin ea = sneg(b); eb = a; tag = "R5"; end
    endcase
    if (a == MINV || b == MINV) tag = {tag, "/R7"};
    if (s) tag = {tag, "/R9"};
    if (v) begin exp_a = ea; exp_b = eb; end
    else tag = "R10";
    if (s) m_phase = (m_phase + 1) % 4;
    @(negedge clk);
    check("R8 valid", int'(out_valid), int'(v));
    check(tag, int'(out_sym_a), exp_a);
    check(tag, int'(out_sym_b), exp_b);
    check("R6 phase", int'(phase_sel), m_phase);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 phase", int'(phase_sel), 0);
    check("R1 valid", int'(out_valid), 0);
    check("R1 a", int'(out_sym_a), 0);
    check("R1 b", int'(out_sym_b), 0);
    rst = 1'b0;
    // each phase, normal and most-negative values
    for (int p = 0; p < 4; p++) begin
      step(1'b0, 1'b1, 3, -5);
      step(1'b0, 1'b1, MINV, 2);
      step(1'b0, 1'b1, -1, MINV);
      step(1'b0, 1'b0, 7, 7);       // R10 hold
      step(1'b1, 1'b0, 0, 0);       // R6 advance on idle clock
    end
    // back at phase 0 after wrap: R6
    check("R6 wrap", int'(phase_sel), 0);
    // slip with valid pair in same cycle: R9
    step(1'b1, 1'b1, 4, -3);
    step(1'b0, 1'b1, 4, -3);
    step(1'b1, 1'b1, MINV, MINV);
    step(1'b0, 1'b1, MINV, MINV);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int ra, rb;
      logic rs, rv;
      ra = int'($signed(4'($urandom)));
      rb = int'($signed(4'($urandom)));
      rs = ($urandom % 8) == 0;
      rv = ($urandom % 4) != 0;
      step(rs, rv, ra, rb);
    end
    // reset mid-stream: R1
    slip = 1'b0; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 phase", int'(phase_sel), 0);
    check("R1 valid", int'(out_valid), 0);
    check("R1 a", int'(out_sym_a), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule